// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects up to 32 interrupt request lines from peripherals and presents them to a processor as one interrupt output. Each line may be configured as level or edge triggered, and as active-high/rising or active-low/falling. Every line is brought into the controller clock domain through a two-flop synchroniser. The synchronised value is then either sampled as a level or compared with its previous value to find an edge. A detected request is held in a per-source latch.

Software reaches the controller through a small word-addressed register window of 0x1000 bytes. Each register has one bit per source, at the bit position of that source. An enable register gates the latched requests into a status register. A clear register acknowledges requests when ones are written to it. The interrupt output is a registered OR of the status bits. Register access uses plain control pins: a strobe, a write flag, an address and write data. Read data is registered and there is no back-pressure, so every access completes in the cycle of its strobe.

Top module: `edge_level_intc`

## Requirements
- R1: After reset, every register reads zero, every request latch is empty and `irq_out` is low.
- R2: Offset 0x00 reads the synchronised source inputs. Bit i is source i. Writes to offset 0x00 are ignored.
- R3: Status (offset 0x14, read-only) bit i is the request latch of source i ANDed with enable (offset 0x04) bit i. A latch fills whether or not its enable bit is set. A request latched while disabled appears in status once the source is enabled.
- R4: Writing a 1 to bit i of the clear register (offset 0x08) empties the latch of source i in that cycle. A 0 bit leaves the latch unchanged. The clear register reads as zero.
- R5: Mode register (offset 0x0C) bit i = 1 makes source i edge triggered. A 0 makes it level triggered, and a level source fills its latch while its input is active.
- R6: Polarity register (offset 0x10) bit i = 1 makes source i active-low (level) or falling-edge (edge). A 0 makes it active-high or rising-edge.
- R7: When a level source is cleared while its input is still active, the clear wins for one cycle: a status read in the next cycle returns 0, and the latch is set again one cycle after the clear.
- R8: An edge request stays latched after the input returns to its idle value, until it is cleared.
- R9: When an edge is detected in the same cycle that the clear register clears that source, the edge wins and the request stays latched.
- R10: `irq_out` is a register holding the OR of all status bits. A latch fills on the third clock edge after the input changes, and `irq_out` follows on the next edge.
- R11: Only offsets 0x00 to 0x14 are decoded, and address bits [1:0] are ignored. Other offsets read zero, and writes to them change nothing.
- R12: `bus_rdata` is loaded on the clock edge where `bus_en` is high with `bus_we` low, and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw interrupt request lines, asynchronous |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
An input change reaches the request latch on the third rising edge and reaches `irq_out` on the fourth. The bench therefore changes sources at a falling edge and checks `irq_out` on both sides of that fourth edge: low three falling edges later, high four falling edges later. A register write lands on the rising edge inside its access cycle, and read data is seen at the falling edge that ends the read. This lets the level re-pend case read 0 right after the clear and 1 one access later. The edge/clear race times the clear write so that it lands on the same rising edge as the edge detection.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  // word index within the window (byte offset / 4)
  typedef enum logic [IDX_W-1:0] {
    RG_RAW    = 3'd0,
    RG_ENABLE = 3'd1,
    RG_CLEAR  = 3'd2,
    RG_MODE   = 3'd3,
    RG_POL    = 3'd4,
    RG_STATUS = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/intc_trigger.sv
`timescale 1ns/1ps
module intc_trigger #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_s,
  input  logic [N-1:0] mode_edge,
  input  logic [N-1:0] pol_low,
  input  logic [N-1:0] clr,
  output logic [N-1:0] prev_s,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise, fall, hit, act;

    always_comb begin
      rise = lvl_s[i] & ~prev_s[i];
      fall = ~lvl_s[i] & prev_s[i];
      hit  = pol_low[i] ? fall : rise;
      act  = pol_low[i] ? ~lvl_s[i] : lvl_s[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_s[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        prev_s[i] <= lvl_s[i];
        if (mode_edge[i])
          pend[i] <= hit | (pend[i] & ~clr[i]);   // new edge beats clear
        else if (clr[i])
          pend[i] <= 1'b0;                        // clear beats level for a cycle
        else
          pend[i] <= pend[i] | act;
      end
    end
  end
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N-1:0]      raw_s,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      clr_pulse,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int HI_LSB = IDX_W + 2;

  logic              hit_win;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok, rd_ok;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_lsb;

  assign unused_lsb = ^bus_addr[1:0];
  assign idx     = bus_addr[HI_LSB-1:2];
  assign hit_win = (bus_addr[ADDR_W-1:HI_LSB] == '0) && (idx <= IDX_W'(RG_STATUS));
  assign wr_ok   = bus_en & bus_we & hit_win;
  assign rd_ok   = bus_en & ~bus_we;

  assign clr_pulse = (wr_ok && idx == RG_CLEAR) ? bus_wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_ok) begin
      case (idx)
        RG_ENABLE: en_q   <= bus_wdata[N-1:0];
        RG_MODE:   mode_q <= bus_wdata[N-1:0];
        RG_POL:    pol_q  <= bus_wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_win) begin
      case (idx)
        RG_RAW:    rd_mux[N-1:0] = raw_s;
        RG_ENABLE: rd_mux[N-1:0] = en_q;
        RG_MODE:   rd_mux[N-1:0] = mode_q;
        RG_POL:    rd_mux[N-1:0] = pol_q;
        RG_STATUS: rd_mux[N-1:0] = status;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_mux;
endmodule

// File: rtl/edge_level_intc.sv
`timescale 1ns/1ps
module edge_level_intc
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [NSRC-1:0] sync_s, prev_s, pend, status;
  logic [NSRC-1:0] en_q, mode_q, pol_q, clr_pulse;

  intc_sync #(.W(NSRC), .STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(src_in), .q_out(sync_s));

  intc_trigger #(.N(NSRC)) trig_i (
    .clk(clk), .rst_n(rst_n), .lvl_s(sync_s), .mode_edge(mode_q),
    .pol_low(pol_q), .clr(clr_pulse), .prev_s(prev_s), .pend(pend));

  intc_regs #(.N(NSRC), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_s(sync_s),
    .status(status), .en_q(en_q), .mode_q(mode_q), .pol_q(pol_q),
    .clr_pulse(clr_pulse), .bus_rdata(bus_rdata));

  assign status = pend & en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |status;
endmodule

// File: rtl/intc_checker.sv
`timescale 1ns/1ps
module intc_checker #(
  parameter int N      = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      sync_s,
  input logic [N-1:0]      prev_s,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      mode_q,
  input logic [N-1:0]      pol_q,
  input logic [N-1:0]      clr_pulse,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out
);
  logic [N-1:0] edge_seen, lvl_on;
  assign edge_seen = (sync_s ^ prev_s) & (sync_s ^ pol_q);
  assign lvl_on    = (sync_s & ~pol_q) | (~sync_s & pol_q);

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & en_q)) |=> irq_out);                                   // R10
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & en_q)) |=> !irq_out);                                 // R10
  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(12'h014))
      |=> ((bus_rdata[N-1:0] & ~$past(en_q)) == '0));               // R3
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mode_q & clr_pulse & edge_seen) & ~pend) == '0)); // R9
  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~mode_q & clr_pulse) & pend) == '0));          // R7
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~mode_q & lvl_on & ~clr_pulse) & ~pend) == '0)); // R5
  AST_ZERO_CLEAR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend & ~clr_pulse) & ~pend) == '0));           // R4
endmodule

bind edge_level_intc intc_checker #(.N(NSRC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .prev_s(prev_s), .pend(pend),
  .en_q(en_q), .mode_q(mode_q), .pol_q(pol_q), .clr_pulse(clr_pulse),
  .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out));

// File: tb/edge_level_intc_tb_top.sv
`timescale 1ns/1ps
module edge_level_intc_tb_top;
  localparam logic [11:0] A_RAW = 12'h000, A_EN = 12'h004, A_CLR = 12'h008,
                          A_MODE = 12'h00C, A_POL = 12'h010, A_STAT = 12'h014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  edge_level_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] m, input logic [31:0] p, input logic [31:0] e);
    wr(A_EN, '0); wr(A_MODE, m); wr(A_POL, p); wr(A_CLR, '1); wr(A_EN, e);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    rd(A_EN, v);   chk("R1 enable", v, 32'd0);
    rd(A_MODE, v); chk("R1 mode", v, 32'd0);
    rd(A_POL, v);  chk("R1 polarity", v, 32'd0);
    rd(A_STAT, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    src_in = 32'hA5C3_0F01; idle(3);
    rd(A_RAW, v); chk("R2 raw view", v, 32'hA5C3_0F01);
    wr(A_RAW, 32'hFFFF_FFFF);
    rd(A_RAW, v); chk("R2 raw write ignored", v, 32'hA5C3_0F01);
    src_in = '0; idle(4);
    wr(A_CLR, '1);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    cfg(32'd0, 32'd0, 32'h0000_0008);
    src_in[3] = 1'b1;
    idle(3); chk("R10 irq not before 4th edge", {31'd0, irq_out}, 32'd0);
    idle(1); chk("R10 irq on 4th edge", {31'd0, irq_out}, 32'd1);
    rd(A_STAT, v); chk("R5 level high pending", v, 32'h8);
    wr(A_CLR, 32'h8);
    rd(A_STAT, v); chk("R7 cleared level reads 0 next cycle", v, 32'h0);
    rd(A_STAT, v); chk("R7 active level re-pends", v, 32'h8);
    src_in[3] = 1'b0; idle(4);
    wr(A_CLR, 32'h8);
    rd(A_STAT, v); chk("R4 clear empties latch", v, 32'h0);
    rd(A_STAT, v); chk("R4 inactive level stays clear", v, 32'h0);
    idle(1); chk("R10 irq low when nothing pending", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    cfg(32'd0, 32'h80, 32'h80);
    idle(4);
    rd(A_STAT, v); chk("R6 active-low level pends on 0", v, 32'h80);
    src_in[7] = 1'b1; idle(4);
    wr(A_CLR, 32'h80); idle(1);
    rd(A_STAT, v); chk("R6 active-low idle at 1", v, 32'h0);
    src_in[7] = 1'b0; wr(A_EN, '0); wr(A_POL, '0); idle(4); wr(A_CLR, '1);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    cfg(32'h20, 32'd0, 32'h20);
    src_in[5] = 1'b1; idle(4);
    rd(A_STAT, v); chk("R5 rising edge pends", v, 32'h20);
    src_in[5] = 1'b0; idle(4);
    rd(A_STAT, v); chk("R8 edge stays after input drops", v, 32'h20);
    wr(A_CLR, 32'h0);
    rd(A_STAT, v); chk("R4 zero clear no effect", v, 32'h20);
    wr(A_CLR, 32'hFFFF_FFDF);
    rd(A_STAT, v); chk("R4 other bits no effect", v, 32'h20);
    wr(A_CLR, 32'h20);
    rd(A_STAT, v); chk("R4 edge cleared", v, 32'h0);
    rd(A_CLR, v);  chk("R4 clear reads zero", v, 32'h0);
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    cfg(32'h200, 32'h200, 32'h200);
    src_in[9] = 1'b1; idle(4);
    rd(A_STAT, v); chk("R6 rising ignored on falling source", v, 32'h0);
    src_in[9] = 1'b0; idle(4);
    rd(A_STAT, v); chk("R6 falling edge pends", v, 32'h200);
    wr(A_CLR, 32'h200); wr(A_POL, '0);
  endtask

  task automatic t_enable_gate();
    logic [31:0] v;
    cfg(32'h1000, 32'd0, 32'd0);
    src_in[12] = 1'b1; idle(4);
    rd(A_STAT, v); chk("R3 disabled source hidden", v, 32'h0);
    chk("R3 irq low while disabled", {31'd0, irq_out}, 32'd0);
    wr(A_EN, 32'h1000);
    rd(A_STAT, v); chk("R3 latched request shown on enable", v, 32'h1000);
    chk("R3 irq after enable", {31'd0, irq_out}, 32'd1);
    src_in[12] = 1'b0; idle(4); wr(A_CLR, '1);
  endtask

  task automatic t_race();
    logic [31:0] v;
    cfg(32'h0010_0000, 32'd0, 32'h0010_0000);
    src_in[20] = 1'b1;
    idle(2);
    wr(A_CLR, 32'h0010_0000);   // lands on the detection edge
    rd(A_STAT, v); chk("R9 edge beats same-cycle clear", v, 32'h0010_0000);
    wr(A_CLR, 32'h0010_0000);
    rd(A_STAT, v); chk("R9 later clear empties", v, 32'h0);
    src_in[20] = 1'b0; idle(4); wr(A_CLR, '1);
  endtask

  task automatic t_irq_or();
    logic [31:0] v;
    cfg(32'h3, 32'd0, 32'h3);
    src_in[1:0] = 2'b11; idle(1); src_in[1:0] = 2'b00; idle(4);
    chk("R10 irq with two pending", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h1);
    idle(1); chk("R10 irq held by remaining source", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h2);
    chk("R10 irq still high one edge after last clear", {31'd0, irq_out}, 32'd1);
    idle(1); chk("R10 irq drops next edge", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    wr(A_EN, 32'h0000_00FF);
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(A_EN, v);    chk("R11 unmapped write ignored", v, 32'h0000_00FF);
    rd(12'h040, v); chk("R11 unmapped reads zero", v, 32'h0);
    rd(12'h01C, v); chk("R11 index 7 reads zero", v, 32'h0);
    rd(12'h006, v); chk("R11 low address bits ignored", v, 32'h0000_00FF);
    rd(12'h804, v); chk("R11 high address bits decoded", v, 32'h0);
  endtask

  task automatic t_rd_timing();
    logic [31:0] v;
    wr(A_MODE, 32'h0000_5A00);
    rd(A_EN, v); chk("R12 read data", v, 32'h0000_00FF);
    idle(2); chk("R12 rdata holds when idle", bus_rdata, 32'h0000_00FF);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = A_MODE;
    #1 chk("R12 rdata not before edge", bus_rdata, 32'h0000_00FF);
    @(negedge clk); bus_en = 1'b0;
    chk("R12 rdata after edge", bus_rdata, 32'h0000_5A00);
    wr(A_MODE, '0); wr(A_EN, '0);
  endtask

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_raw();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_enable_gate();
    t_race();
    t_irq_or();
    t_decode();
    t_rd_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule